// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block is a reusable completion barrier for producer/consumer handoff. Software first loads it with the number of arrivals that make up one phase. Producers then post arrivals. An arrival can be plain, or it can also announce a number of asynchronous bytes that are still on their way. A separate landing port reports bytes as they arrive. The current phase completes only when every expected arrival has been posted and the outstanding byte total has drained to zero. On completion the barrier flips a phase bit, reloads its arrival count, and is ready for the next round without being loaded again.

Consumers never read a done flag. They present the parity of the phase they are waiting on and are told whether the barrier has moved past it. A single-cycle poll port answers in the same cycle and leaves retrying to the requester. A blocking wait port is held high by the requester and reports ready for as long as the condition holds. The error cases are byte reports larger than the outstanding total and arrivals beyond the expected count. Both raise an error flag, and in both cases the barrier still behaves deterministically.

Top module: `txn_phase_barrier`

## Requirements
- R1: An init request loads the arrival count, with a count of 0 taken as 1. It also clears the phase bit to 0, clears the outstanding bytes and the error flag, and sets `initialized`. Arrivals and landings presented in the same cycle as init are dropped.
- R2: An arrival with `arv_tx`=1 counts as one arrival and adds `arv_bytes` to the outstanding total. The phase does not complete until landings have brought that total to zero.
- R3: An arrival with `arv_tx`=0 counts as one arrival and carries no byte expectation.
- R4: Completion happens at the clock edge where the remaining arrivals reach 0 and the outstanding bytes reach 0. At that edge `phase` toggles and `phase_done` is high for exactly one cycle. The arrival count also reloads and the byte total clears, so the barrier can be reused without a new init.
- R5: `poll_ready` is combinational in the same cycle. It is 1 only when `poll_valid`=1 and `phase` differs from `poll_parity`, and it is 0 when `poll_valid`=0.
- R6: `wait_done` is 1 on every cycle where `wait_req` is held high and `phase` differs from `wait_parity`. It is 0 while the two are equal.
- R7: Byte expectations from several arrivals within one phase add up into a single outstanding total.
- R8: A landing and an arrival in the same cycle are both applied, and completion is evaluated on the combined result.
- R9: If fewer bytes land than were expected, the phase never completes. If a landing exceeds the outstanding total, the total clamps at 0, `err` is set, and completion is evaluated on the clamped value.
- R10: An arrival presented while no arrivals remain in the phase is ignored, including its bytes, and `err` is set.
- R11: With the default `ERR_STICKY`=1, `err` stays high until the next init.
- R12: Before the first init, `initialized`=0, arrivals and landings are ignored, and `poll_ready` and `wait_done` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_valid | input | 1 | Load the barrier |
| init_count | input | CNT_W | Arrivals per phase |
| arv_valid | input | 1 | Post one arrival |
| arv_tx | input | 1 | 1: arrival also expects bytes |
| arv_bytes | input | BYTE_W | Bytes expected by this arrival |
| land_valid | input | 1 | Byte landing report |
| land_bytes | input | BYTE_W | Bytes landed |
| poll_valid | input | 1 | Non-blocking parity probe |
| poll_parity | input | 1 | Parity being probed |
| poll_ready | output | 1 | Probe result, same cycle |
| wait_req | input | 1 | Held blocking wait request |
| wait_parity | input | 1 | Parity being waited on |
| wait_done | output | 1 | Blocking wait satisfied |
| phase | output | 1 | Current phase bit |
| phase_done | output | 1 | One-cycle completion pulse |
| initialized | output | 1 | Barrier has been loaded |
| err | output | 1 | Byte underflow or excess arrival |

## Verification
The main function is exercised with four kinds of input sequence. Plain arrivals against a count of two separate counting arrivals from completing on the first one. A single byte-expecting arrival drained by two partial landings shows that the byte total, and not the arrival count, holds the phase open. Two byte-expecting arrivals drained in a different split show that the expectations accumulate. An arrival and a landing in the same cycle tell apart an implementation that applies both from one that drops or serialises one of them. Under-delivery, over-delivery, an extra arrival, a zero count at init and traffic before init then probe each defined misuse. Parity probes taken on both sides of a toggle separate a parity comparison from a done flag.

// File: rtl/txpb_pkg.sv
package txpb_pkg;
   typedef enum logic {
      ARV_PLAIN  = 1'b0,
      ARV_EXPECT = 1'b1
   } arv_kind_e;
endpackage

// File: rtl/txpb_arrivals.sv
module txpb_arrivals #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             take,
   input  logic             complete,
   output logic [CNT_W-1:0] pend,
   output logic             zero_next
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, expect_q, load_eff;

   always_comb begin
      cnt_d     = take ? (cnt_q - ONE) : cnt_q;
      zero_next = (cnt_d == '0);
      load_eff  = (load_cnt == '0) ? ONE : load_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         expect_q <= ONE;
      end else if (load) begin
         cnt_q    <= load_eff;
         expect_q <= load_eff;
      end else if (complete) begin
         cnt_q    <= expect_q;
      end else begin
         cnt_q    <= cnt_d;
      end
   end

   assign pend = cnt_q;
endmodule

// File: rtl/txpb_bytes.sv
module txpb_bytes #(
   parameter int BYTE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              add_en,
   input  logic [BYTE_W-1:0] add_amt,
   input  logic              sub_en,
   input  logic [BYTE_W-1:0] sub_amt,
   input  logic              complete,
   output logic [BYTE_W-1:0] pend,
   output logic              zero_next,
   output logic              underflow
);
   localparam int SUM_W = BYTE_W + 1;
   localparam logic [BYTE_W-1:0] MAXV = {BYTE_W{1'b1}};

   logic [BYTE_W-1:0] q, d;
   logic [SUM_W-1:0]  sum, sub, diff;

   always_comb begin
      sum       = {1'b0, q} + (add_en ? {1'b0, add_amt} : '0);
      sub       = sub_en ? {1'b0, sub_amt} : '0;
      underflow = (sub > sum);
      diff      = underflow ? '0 : (sum - sub);
      d         = diff[BYTE_W] ? MAXV : diff[BYTE_W-1:0];
      zero_next = (d == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (clear || complete) q <= '0;
      else                       q <= d;
   end

   assign pend = q;
endmodule

// File: rtl/txpb_waiters.sv
module txpb_waiters (
   input  logic armed,
   input  logic phase,
   input  logic poll_valid,
   input  logic poll_parity,
   input  logic wait_req,
   input  logic wait_parity,
   output logic poll_ready,
   output logic wait_done
);
   logic poll_past, wait_past;

   always_comb begin
      poll_past  = phase ^ poll_parity;
      wait_past  = phase ^ wait_parity;
      poll_ready = armed & poll_valid & poll_past;
      wait_done  = armed & wait_req & wait_past;
   end
endmodule

// File: rtl/txn_phase_barrier.sv
module txn_phase_barrier
   import txpb_pkg::*;
#(
   parameter int CNT_W      = 6,
   parameter int BYTE_W     = 16,
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_valid,
   input  logic [CNT_W-1:0]  init_count,
   input  logic              arv_valid,
   input  logic              arv_tx,
   input  logic [BYTE_W-1:0] arv_bytes,
   input  logic              land_valid,
   input  logic [BYTE_W-1:0] land_bytes,
   input  logic              poll_valid,
   input  logic              poll_parity,
   output logic              poll_ready,
   input  logic              wait_req,
   input  logic              wait_parity,
   output logic              wait_done,
   output logic              phase,
   output logic              phase_done,
   output logic              initialized,
   output logic              err
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("txn_phase_barrier: CNT_W must be 1..16");
   end
   if (BYTE_W < 1 || BYTE_W > 32) begin : g_bad_byte
      $error("txn_phase_barrier: BYTE_W must be 1..32");
   end

   logic [CNT_W-1:0]  pend_arr;
   logic [BYTE_W-1:0] pend_bytes;
   logic              live, take, excess, add_en, sub_en;
   logic              arr_zero, byte_zero, underflow, complete, fault;
   arv_kind_e         kind;

   always_comb begin
      kind     = arv_kind_e'(arv_tx);
      live     = initialized & ~init_valid;
      take     = live & arv_valid & (pend_arr != '0);
      excess   = live & arv_valid & (pend_arr == '0);
      add_en   = take & (kind == ARV_EXPECT);
      sub_en   = live & land_valid;
      complete = live & arr_zero & byte_zero;
      fault    = excess | (sub_en & underflow);
   end

   txpb_arrivals #(.CNT_W(CNT_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (init_valid),
      .load_cnt  (init_count),
      .take      (take),
      .complete  (complete),
      .pend      (pend_arr),
      .zero_next (arr_zero)
   );

   txpb_bytes #(.BYTE_W(BYTE_W)) u_bytes (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (init_valid),
      .add_en    (add_en),
      .add_amt   (arv_bytes),
      .sub_en    (sub_en),
      .sub_amt   (land_bytes),
      .complete  (complete),
      .pend      (pend_bytes),
      .zero_next (byte_zero),
      .underflow (underflow)
   );

   txpb_waiters u_wait (
      .armed       (initialized),
      .phase       (phase),
      .poll_valid  (poll_valid),
      .poll_parity (poll_parity),
      .wait_req    (wait_req),
      .wait_parity (wait_parity),
      .poll_ready  (poll_ready),
      .wait_done   (wait_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= 1'b0;
         phase_done  <= 1'b0;
         initialized <= 1'b0;
      end else if (init_valid) begin
         phase       <= 1'b0;
         phase_done  <= 1'b0;
         initialized <= 1'b1;
      end else begin
         phase       <= phase ^ complete;
         phase_done  <= complete;
      end
   end

   if (ERR_STICKY) begin : g_err_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          err <= 1'b0;
         else if (init_valid) err <= 1'b0;
         else if (fault)      err <= 1'b1;
      end
   end else begin : g_err_pulse
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err <= 1'b0;
         else        err <= fault & ~init_valid;
      end
   end
endmodule

// File: rtl/txpb_checker.sv
module txpb_checker #(
   parameter int CNT_W      = 6,
   parameter int BYTE_W     = 16,
   parameter bit ERR_STICKY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_valid,
   input logic              arv_valid,
   input logic              land_valid,
   input logic              poll_ready,
   input logic              wait_done,
   input logic              phase,
   input logic              phase_done,
   input logic              initialized,
   input logic              err,
   input logic [CNT_W-1:0]  pend_arr,
   input logic [BYTE_W-1:0] pend_bytes
);
   a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      init_valid |=> (!phase && initialized && !err));

   a_r2_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (initialized && !init_valid && !land_valid && pend_bytes != '0)
      |=> phase == $past(phase));

   a_r3_arrivals_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (initialized && !init_valid && !arv_valid && pend_arr != '0)
      |=> phase == $past(phase));

   a_r4_toggle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(init_valid) && phase != $past(phase)) |-> phase_done);

   a_r10_excess_err: assert property (@(posedge clk) disable iff (!rst_n)
      (initialized && !init_valid && arv_valid && pend_arr == '0) |=> err);

   a_r12_idle_before_init: assert property (@(posedge clk) disable iff (!rst_n)
      !initialized |-> (!poll_ready && !wait_done));

   if (ERR_STICKY) begin : g_sticky
      a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (err && !init_valid) |=> err);
   end
endmodule

bind txn_phase_barrier txpb_checker #(
   .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ERR_STICKY(ERR_STICKY)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .init_valid  (init_valid),
   .arv_valid   (arv_valid),
   .land_valid  (land_valid),
   .poll_ready  (poll_ready),
   .wait_done   (wait_done),
   .phase       (phase),
   .phase_done  (phase_done),
   .initialized (initialized),
   .err         (err),
   .pend_arr    (pend_arr),
   .pend_bytes  (pend_bytes)
);

// File: tb/sim_txn_phase_barrier.sv
module sim_txn_phase_barrier;
   localparam int CW = 6;
   localparam int BW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_valid = 0, arv_valid = 0, arv_tx = 0, land_valid = 0;
   logic poll_valid = 0, poll_parity = 0, wait_req = 0, wait_parity = 0;
   logic [CW-1:0] init_count = '0;
   logic [BW-1:0] arv_bytes = '0, land_bytes = '0;
   logic poll_ready, wait_done, phase, phase_done, initialized, err;

   int  n_chk = 0, n_fail = 0;
   logic exp_ph = 1'b0;
   bit  finished = 0;

   always #5 clk = ~clk;

   txn_phase_barrier #(.CNT_W(CW), .BYTE_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_count(init_count),
      .arv_valid(arv_valid), .arv_tx(arv_tx), .arv_bytes(arv_bytes),
      .land_valid(land_valid), .land_bytes(land_bytes),
      .poll_valid(poll_valid), .poll_parity(poll_parity), .poll_ready(poll_ready),
      .wait_req(wait_req), .wait_parity(wait_parity), .wait_done(wait_done),
      .phase(phase), .phase_done(phase_done), .initialized(initialized), .err(err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Each step presents inputs for one edge; returns at the following negedge.
   task automatic step(input bit ini, input int cnt, input bit arv, input bit tx,
                       input int ab, input bit lnd, input int lb);
      @(negedge clk);
      init_valid = ini; init_count = CW'(cnt);
      arv_valid = arv; arv_tx = tx; arv_bytes = BW'(ab);
      land_valid = lnd; land_bytes = BW'(lb);
      @(negedge clk);
      init_valid = 0; arv_valid = 0; arv_tx = 0; land_valid = 0;
   endtask

   task automatic do_init(input int cnt);
      step(1, cnt, 0, 0, 0, 0, 0);
      exp_ph = 1'b0;
   endtask

   task automatic t_reset_preinit();
      #1;
      chk("R12 initialized after reset", initialized, 0);
      chk("R12 phase after reset", phase, 0);
      step(0, 0, 1, 0, 0, 1, 3);
      chk("R12 arrival before init ignored", phase_done, 0);
      chk("R12 err before init", err, 0);
      poll_valid = 1; poll_parity = 1; wait_req = 1; wait_parity = 1; #1;
      chk("R12 poll not ready before init", poll_ready, 0);
      chk("R12 wait not ready before init", wait_done, 0);
      poll_valid = 0; wait_req = 0;
   endtask

   task automatic t_plain();
      do_init(2);
      chk("R1 initialized", initialized, 1);
      chk("R1 phase cleared", phase, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R3 first of two arrivals", phase, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R4 phase toggles", phase, 1);
      chk("R4 done pulse", phase_done, 1);
      @(negedge clk);
      chk("R4 pulse one cycle", phase_done, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R4 reload count", phase, 1);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R4 reuse toggles back", phase, 0);
   endtask

   task automatic t_tx();
      do_init(1);
      step(0, 0, 1, 1, 16, 0, 0);
      chk("R2 arrival waits for bytes", phase, 0);
      step(0, 0, 0, 0, 0, 1, 10);
      chk("R2 partial landing", phase, 0);
      step(0, 0, 0, 0, 0, 1, 6);
      chk("R2 completes on drain", phase, 1);
      chk("R2 no error", err, 0);
   endtask

   task automatic t_accum();
      do_init(2);
      step(0, 0, 1, 1, 8, 0, 0);
      step(0, 0, 1, 1, 24, 0, 0);
      chk("R7 all arrivals, bytes pending", phase, 0);
      step(0, 0, 0, 0, 0, 1, 20);
      chk("R7 sum not drained", phase, 0);
      step(0, 0, 0, 0, 0, 1, 12);
      chk("R7 summed total drained", phase, 1);
      chk("R7 no error", err, 0);
   endtask

   task automatic t_same_cycle();
      do_init(1);
      step(0, 0, 1, 1, 4, 1, 4);
      chk("R8 arrive+land same cycle completes", phase, 1);
      chk("R8 no underflow", err, 0);
      do_init(2);
      step(0, 0, 1, 1, 6, 0, 0);
      step(0, 0, 1, 0, 0, 1, 6);
      chk("R8 last arrival with final landing", phase, 1);
   endtask

   task automatic t_under();
      do_init(1);
      step(0, 0, 1, 1, 16, 0, 0);
      step(0, 0, 0, 0, 0, 1, 8);
      repeat (5) @(negedge clk);
      chk("R9 under-delivery never completes", phase, 0);
      poll_valid = 1; poll_parity = 0; #1;
      chk("R9 poll not ready", poll_ready, 0);
      poll_valid = 0;
   endtask

   task automatic t_over();
      do_init(1);
      step(0, 0, 1, 1, 8, 0, 0);
      step(0, 0, 0, 0, 0, 1, 12);
      chk("R9 over-delivery clamps and completes", phase, 1);
      chk("R9 over-delivery err", err, 1);
      repeat (3) @(negedge clk);
      chk("R11 err sticky", err, 1);
      do_init(1);
      chk("R1 init clears err", err, 0);
   endtask

   task automatic t_extra();
      do_init(1);
      step(0, 0, 1, 1, 8, 0, 0);
      step(0, 0, 1, 1, 5, 0, 0);
      chk("R10 extra arrival err", err, 1);
      chk("R10 extra arrival no completion", phase, 0);
      step(0, 0, 0, 0, 0, 1, 8);
      chk("R10 extra bytes not added", phase, 1);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R10 count reloaded to 1", phase, 0);
   endtask

   task automatic t_poll_wait();
      do_init(1);
      poll_valid = 1; poll_parity = 0; #1;
      chk("R5 poll same parity not ready", poll_ready, 0);
      poll_parity = 1; #1;
      chk("R5 poll other parity ready", poll_ready, 1);
      poll_valid = 0; #1;
      chk("R5 no poll no ready", poll_ready, 0);
      wait_req = 1; wait_parity = 0; #1;
      chk("R6 wait blocked", wait_done, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R6 wait satisfied", wait_done, 1);
      repeat (3) @(negedge clk);
      chk("R6 wait held ready", wait_done, 1);
      wait_parity = 1; #1;
      chk("R6 parity equal to phase blocks", wait_done, 0);
      wait_req = 0;
   endtask

   task automatic t_reinit_zero();
      step(1, 0, 1, 0, 0, 1, 2);
      chk("R1 init wins over arrival", phase, 0);
      chk("R1 no err on init cycle", err, 0);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R1 zero count taken as one", phase, 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_preinit();
      t_plain();
      t_tx();
      t_accum();
      t_same_cycle();
      t_under();
      t_over();
      t_extra();
      t_poll_wait();
      t_reinit_zero();
      finished = 1;
      summary();
      $finish;
   end
endmodule